// File: doc/BRIEF.md
# Machine Status Register with Trap Sequencing

This block holds the 64-bit machine status word of a hart that runs in machine (M), supervisor (S) and user (U) privilege levels. It also owns the current-privilege register. Software reads and writes the word through a plain CSR port. The trap logic drives three kinds of strobe: trap entry (with the target level and the level the hart came from), machine return and supervisor return.

On trap entry, the block saves the interrupt enable and the previous privilege into their stack fields. On return, it restores them. When the floating-point or vector unit reports a register write, the matching context-state field is set to dirty, and the top bit summarises dirty state. Software writes of a reserved privilege code are kept out of the machine previous-privilege field. Fields that are not implemented read back as constants.

Top module: `hart_status_csr`

## Requirements
- R1: After reset the current privilege is M (3) and the read value is 0x0000_000A_0000_1800. That value has MPP (bits 12:11) = 3, MIE (bit 3) = 0, MPRV (bit 17) = 0, SXL (bits 35:34) = 2, UXL (bits 33:32) = 2, and every other bit 0.
- R2: A trap entry into M sets MPIE (bit 7) to the old MIE, clears MIE, loads MPP with the supplied prior level and makes the privilege M.
- R3: A trap entry into S sets SPIE (bit 5) to the old SIE (bit 1), clears SIE, loads SPP (bit 8) with bit 0 of the prior level and makes the privilege S (1).
- R4: A machine return sets the privilege to MPP, sets MIE to MPIE, sets MPIE to 1 and sets MPP to U (0).
- R5: A supervisor return sets the privilege to {0, SPP}, sets SIE to SPIE, sets SPIE to 1 and clears SPP.
- R6: Either return clears MPRV (bit 17).
- R7: The floating-point dirty strobe forces FS (bits 14:13) to 3. The vector dirty strobe forces VS (bits 10:9) to 3. A software write stores any value 0 to 3 in either field.
- R8: Bit 63 reads 1 exactly when FS, VS or XS (bits 16:15) equals 3.
- R9: XS, bits 37, 36 and 6, and bits 39:38 read 0. SXL and UXL read 2. Writes to all of these are ignored.
- R10: A software write of 2 to MPP leaves MPP unchanged. Writes of 0, 1 or 3 are stored.
- R11: In one cycle, trap entry wins over a machine return, a machine return wins over a supervisor return, and any of them wins over a CSR write, which is then dropped. A dirty strobe overrides a written FS or VS value.
- R12: The output mIntEn equals MIE and sIntEn equals SIE. mRetPriv equals MPP and sRetPriv equals {0, SPP}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWe | input | 1 | Software write strobe |
| csrWdata | input | 64 | Software write value |
| csrRdata | output | 64 | Current register value |
| trapValid | input | 1 | Trap entry strobe |
| trapToS | input | 1 | Trap target: 1 = S, 0 = M |
| trapPrevPriv | input | 2 | Privilege level before the trap |
| mretValid | input | 1 | Machine return strobe |
| sretValid | input | 1 | Supervisor return strobe |
| fpDirty | input | 1 | Floating-point register or CSR written |
| vecDirty | input | 1 | Vector register written |
| curPriv | output | 2 | Current privilege level |
| mRetPriv | output | 2 | Level a machine return would enter |
| sRetPriv | output | 2 | Level a supervisor return would enter |
| mIntEn | output | 1 | Machine interrupt enable |
| sIntEn | output | 1 | Supervisor interrupt enable |

## Verification
Every strobe and write is captured on the clock edge that follows its presentation. All results are therefore due one cycle after the stimulus. This applies to the stacked fields, the privilege, the dirty fields and the summary bit alike, because the outputs decode the registers with no further stage. The bench drives each stimulus for one cycle from a falling edge. It then samples all outputs at the next falling edge, just after the updating rising edge, and removes the stimulus at that same moment so that no second update can occur.

// File: rtl/hstat_pkg.sv
package hstat_pkg;

  localparam int unsigned XLEN = 64;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  // bit positions of the status word
  localparam int unsigned B_SIE  = 1;
  localparam int unsigned B_MIE  = 3;
  localparam int unsigned B_SPIE = 5;
  localparam int unsigned B_MPIE = 7;
  localparam int unsigned B_SPP  = 8;
  localparam int unsigned B_VS   = 9;
  localparam int unsigned B_MPP  = 11;
  localparam int unsigned B_FS   = 13;
  localparam int unsigned B_XS   = 15;
  localparam int unsigned B_MPRV = 17;
  localparam int unsigned B_SUM  = 18;
  localparam int unsigned B_MXR  = 19;
  localparam int unsigned B_TVM  = 20;
  localparam int unsigned B_TW   = 21;
  localparam int unsigned B_TSR  = 22;
  localparam int unsigned B_UXL  = 32;
  localparam int unsigned B_SXL  = 34;
  localparam int unsigned B_SD   = XLEN - 1;

  localparam logic [1:0] CTX_DIRTY = 2'd3;

  // strobes from control to datapath, already prioritised
  typedef struct packed {
    logic trapM;
    logic trapS;
    logic retM;
    logic retS;
    logic swWrite;
    logic fpDirty;
    logic vecDirty;
  } hstatStrobe_t;

  // stored state of the status word
  typedef struct packed {
    logic       sie;
    logic       mie;
    logic       spie;
    logic       mpie;
    logic       spp;
    logic [1:0] vs;
    logic [1:0] mpp;
    logic [1:0] fs;
    logic       mprv;
    logic       sum;
    logic       mxr;
    logic       tvm;
    logic       tw;
    logic       tsr;
  } hstatFields_t;

endpackage

// File: rtl/hstat_ctrl.sv
module hstat_ctrl
  import hstat_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         trapValid,
  input  logic         trapToS,
  input  logic         mretValid,
  input  logic         sretValid,
  input  logic         csrWe,
  input  logic         fpDirty,
  input  logic         vecDirty,
  input  logic [1:0]   mppIn,
  input  logic         sppIn,
  output hstatStrobe_t strobe,
  output logic [1:0]   curPriv
);

  priv_e privQ;
  priv_e privNext;

  always_comb begin
    strobe          = '0;
    strobe.trapM    = trapValid && !trapToS;
    strobe.trapS    = trapValid && trapToS;
    strobe.retM     = !trapValid && mretValid;
    strobe.retS     = !trapValid && !mretValid && sretValid;
    strobe.swWrite  = !trapValid && !mretValid && !sretValid && csrWe;
    strobe.fpDirty  = fpDirty;
    strobe.vecDirty = vecDirty;
  end

  always_comb begin
    privNext = privQ;
    if (strobe.trapM) begin
      privNext = PRIV_M;
    end else if (strobe.trapS) begin
      privNext = PRIV_S;
    end else if (strobe.retM) begin
      privNext = priv_e'(mppIn);
    end else if (strobe.retS) begin
      privNext = sppIn ? PRIV_S : PRIV_U;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      privQ <= PRIV_M;
    end else begin
      privQ <= privNext;
    end
  end

  assign curPriv = privQ;

  // R1 R10
  priv_never_rsvd_chk: assert property (@(posedge clk) disable iff (!rstN)
    curPriv != PRIV_RSVD);

  // R2
  trap_m_priv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trapValid && !trapToS) |=> curPriv == PRIV_M);

  // R4
  mret_priv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mretValid && !trapValid) |=> curPriv == $past(mppIn));

  // R5
  sret_priv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sretValid && !mretValid && !trapValid) |=> curPriv == {1'b0, $past(sppIn)});

endmodule

// File: rtl/hstat_dpath.sv
module hstat_dpath
  import hstat_pkg::*;
#(
  parameter logic [1:0] XL_CODE = 2'd2
) (
  input  logic              clk,
  input  logic              rstN,
  input  hstatStrobe_t      strobe,
  input  logic [XLEN-1:0]   wdata,
  input  logic [1:0]        trapPrev,
  output logic [XLEN-1:0]   rdata,
  output logic [1:0]        mppOut,
  output logic              sppOut,
  output logic              mieOut,
  output logic              sieOut
);

  localparam logic [1:0] XS_CONST = 2'd0;

  hstatFields_t fq;
  hstatFields_t fNext;
  logic [1:0]   wrMpp;

  // reserved code 2 is not stored
  assign wrMpp = (wdata[B_MPP +: 2] == PRIV_RSVD) ? fq.mpp : wdata[B_MPP +: 2];

  always_comb begin
    fNext = fq;
    if (strobe.trapM) begin
      fNext.mpie = fq.mie;
      fNext.mie  = 1'b0;
      fNext.mpp  = trapPrev;
    end else if (strobe.trapS) begin
      fNext.spie = fq.sie;
      fNext.sie  = 1'b0;
      fNext.spp  = trapPrev[0];
    end else if (strobe.retM) begin
      fNext.mie  = fq.mpie;
      fNext.mpie = 1'b1;
      fNext.mpp  = PRIV_U;
      fNext.mprv = 1'b0;
    end else if (strobe.retS) begin
      fNext.sie  = fq.spie;
      fNext.spie = 1'b1;
      fNext.spp  = 1'b0;
      fNext.mprv = 1'b0;
    end else if (strobe.swWrite) begin
      fNext.sie  = wdata[B_SIE];
      fNext.mie  = wdata[B_MIE];
      fNext.spie = wdata[B_SPIE];
      fNext.mpie = wdata[B_MPIE];
      fNext.spp  = wdata[B_SPP];
      fNext.vs   = wdata[B_VS +: 2];
      fNext.mpp  = wrMpp;
      fNext.fs   = wdata[B_FS +: 2];
      fNext.mprv = wdata[B_MPRV];
      fNext.sum  = wdata[B_SUM];
      fNext.mxr  = wdata[B_MXR];
      fNext.tvm  = wdata[B_TVM];
      fNext.tw   = wdata[B_TW];
      fNext.tsr  = wdata[B_TSR];
    end
    if (strobe.fpDirty) begin
      fNext.fs = CTX_DIRTY;
    end
    if (strobe.vecDirty) begin
      fNext.vs = CTX_DIRTY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fq     <= '0;
      fq.mpp <= PRIV_M;
    end else begin
      fq <= fNext;
    end
  end

  always_comb begin
    rdata              = '0;
    rdata[B_SIE]       = fq.sie;
    rdata[B_MIE]       = fq.mie;
    rdata[B_SPIE]      = fq.spie;
    rdata[B_MPIE]      = fq.mpie;
    rdata[B_SPP]       = fq.spp;
    rdata[B_VS +: 2]   = fq.vs;
    rdata[B_MPP +: 2]  = fq.mpp;
    rdata[B_FS +: 2]   = fq.fs;
    rdata[B_XS +: 2]   = XS_CONST;
    rdata[B_MPRV]      = fq.mprv;
    rdata[B_SUM]       = fq.sum;
    rdata[B_MXR]       = fq.mxr;
    rdata[B_TVM]       = fq.tvm;
    rdata[B_TW]        = fq.tw;
    rdata[B_TSR]       = fq.tsr;
    rdata[B_UXL +: 2]  = XL_CODE;
    rdata[B_SXL +: 2]  = XL_CODE;
    rdata[B_SD]        = (fq.fs == CTX_DIRTY) || (fq.vs == CTX_DIRTY) ||
                         (XS_CONST == CTX_DIRTY);
  end

  assign mppOut = fq.mpp;
  assign sppOut = fq.spp;
  assign mieOut = fq.mie;
  assign sieOut = fq.sie;

  // R2
  trap_m_stack_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trapM |=> (!rdata[B_MIE] && rdata[B_MPIE] == $past(fq.mie) &&
                      rdata[B_MPP +: 2] == $past(trapPrev)));

  // R3
  trap_s_stack_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.trapS |=> (!rdata[B_SIE] && rdata[B_SPIE] == $past(fq.sie)));

  // R6
  ret_clears_mprv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.retM || strobe.retS) |=> !rdata[B_MPRV]);

  // R7 R8
  fp_dirty_sd_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fpDirty |=> (rdata[B_FS +: 2] == CTX_DIRTY && rdata[B_SD]));

  // R7 R8
  vec_dirty_sd_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.vecDirty |=> (rdata[B_VS +: 2] == CTX_DIRTY && rdata[B_SD]));

  // R10
  mpp_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.swWrite && wdata[B_MPP +: 2] == PRIV_RSVD) |=> $stable(fq.mpp));

endmodule

// File: rtl/hart_status_csr.sv
module hart_status_csr
  import hstat_pkg::*;
#(
  parameter logic [1:0] XL_CODE = 2'd2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csrWe,
  input  logic [63:0]     csrWdata,
  output logic [63:0]     csrRdata,
  input  logic            trapValid,
  input  logic            trapToS,
  input  logic [1:0]      trapPrevPriv,
  input  logic            mretValid,
  input  logic            sretValid,
  input  logic            fpDirty,
  input  logic            vecDirty,
  output logic [1:0]      curPriv,
  output logic [1:0]      mRetPriv,
  output logic [1:0]      sRetPriv,
  output logic            mIntEn,
  output logic            sIntEn
);

  hstatStrobe_t strobe;
  logic [1:0]   mppW;
  logic         sppW;

  hstat_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .trapValid (trapValid),
    .trapToS   (trapToS),
    .mretValid (mretValid),
    .sretValid (sretValid),
    .csrWe     (csrWe),
    .fpDirty   (fpDirty),
    .vecDirty  (vecDirty),
    .mppIn     (mppW),
    .sppIn     (sppW),
    .strobe    (strobe),
    .curPriv   (curPriv)
  );

  hstat_dpath #(.XL_CODE(XL_CODE)) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wdata    (csrWdata),
    .trapPrev (trapPrevPriv),
    .rdata    (csrRdata),
    .mppOut   (mppW),
    .sppOut   (sppW),
    .mieOut   (mIntEn),
    .sieOut   (sIntEn)
  );

  assign mRetPriv = mppW;
  assign sRetPriv = {1'b0, sppW};

endmodule

// File: tb/test_hart_status_csr.sv
`timescale 1ns/1ps
module test_hart_status_csr;

  typedef struct packed {
    logic [2:0]  op;      // 1 write, 2 trap M, 3 trap S, 4 mret, 5 sret
    logic [63:0] data;    // write value or prior level
    logic [1:0]  expPriv;
    logic [1:0]  expMpp;
    logic        expMie;
    logic        expMpie;
    logic        expSie;
    logic        expSpie;
    logic        expSpp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{3'd1, 64'h00A,  2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    '{3'd2, 64'd3,    2'd3, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{3'd4, 64'd0,    2'd3, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
    '{3'd1, 64'h90A,  2'd3, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{3'd4, 64'd0,    2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    '{3'd3, 64'd1,    2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    '{3'd5, 64'd0,    2'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{3'd5, 64'd0,    2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{3'd3, 64'd0,    2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{3'd2, 64'd1,    2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd1, 64'h1000, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd4, 64'd0,    2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  localparam logic [63:0] RESET_VAL = 64'h0000_000A_0000_1800;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWe = 1'b0;
  logic [63:0] csrWdata = '0;
  logic [63:0] csrRdata;
  logic        trapValid = 1'b0;
  logic        trapToS = 1'b0;
  logic [1:0]  trapPrevPriv = '0;
  logic        mretValid = 1'b0;
  logic        sretValid = 1'b0;
  logic        fpDirty = 1'b0;
  logic        vecDirty = 1'b0;
  logic [1:0]  curPriv, mRetPriv, sRetPriv;
  logic        mIntEn, sIntEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hart_status_csr i_hart_status_csr (
    .clk(clk), .rstN(rstN), .csrWe(csrWe), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .trapValid(trapValid), .trapToS(trapToS), .trapPrevPriv(trapPrevPriv),
    .mretValid(mretValid), .sretValid(sretValid), .fpDirty(fpDirty), .vecDirty(vecDirty),
    .curPriv(curPriv), .mRetPriv(mRetPriv), .sRetPriv(sRetPriv),
    .mIntEn(mIntEn), .sIntEn(sIntEn)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%h expected 0x%h", req, act, exp);
    end
  endtask

  // drive one cycle from a falling edge; return at the next falling edge
  task automatic step(input logic we, input logic [63:0] wd, input logic tv, input logic ts,
                      input logic [1:0] pp, input logic mr, input logic sr,
                      input logic fd, input logic vd);
    csrWe = we; csrWdata = wd; trapValid = tv; trapToS = ts; trapPrevPriv = pp;
    mretValid = mr; sretValid = sr; fpDirty = fd; vecDirty = vd;
    @(negedge clk);
    csrWe = 1'b0; csrWdata = '0; trapValid = 1'b0; trapToS = 1'b0; trapPrevPriv = '0;
    mretValid = 1'b0; sretValid = 1'b0; fpDirty = 1'b0; vecDirty = 1'b0;
  endtask

  task automatic swWrite(input logic [63:0] wd);
    step(1'b1, wd, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  function automatic string opReq(input logic [2:0] op);
    case (op)
      3'd1:    return "R10";
      3'd2:    return "R2";
      3'd3:    return "R3";
      3'd4:    return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1 reset state
    check("R1", csrRdata, RESET_VAL);
    check("R1", {62'd0, curPriv}, 64'd3);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].op)
        3'd1: swWrite(VECS[i].data);
        3'd2: step(1'b0, '0, 1'b1, 1'b0, VECS[i].data[1:0], 1'b0, 1'b0, 1'b0, 1'b0);
        3'd3: step(1'b0, '0, 1'b1, 1'b1, VECS[i].data[1:0], 1'b0, 1'b0, 1'b0, 1'b0);
        3'd4: step(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        default: step(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
      endcase
      check(opReq(VECS[i].op), {62'd0, curPriv}, {62'd0, VECS[i].expPriv});
      check(opReq(VECS[i].op),
            {57'd0, csrRdata[12:11], csrRdata[3], csrRdata[7], csrRdata[1], csrRdata[5], csrRdata[8]},
            {57'd0, VECS[i].expMpp, VECS[i].expMie, VECS[i].expMpie, VECS[i].expSie,
             VECS[i].expSpie, VECS[i].expSpp});
    end

    // R11 trap wins over a write in the same cycle
    step(1'b1, '1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R11", {62'd0, curPriv}, 64'd3);
    check("R11", {58'd0, csrRdata[22:17]}, 64'd0);
    check("R11", {61'd0, csrRdata[12:11], csrRdata[1]}, {61'd0, 2'd1, 1'b0});

    // R11 trap M wins over mret; mret wins over sret
    step(1'b0, '0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R11", {62'd0, curPriv}, 64'd3);
    check("R11", {62'd0, csrRdata[12:11]}, 64'd0);
    swWrite(64'h0000_0000_0000_0900);
    step(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R11", {62'd0, curPriv}, 64'd1);
    check("R11", {63'd0, csrRdata[8]}, 64'd1);

    // R9 R8 all-ones write: read-only bits ignored, SD set
    swWrite('1);
    check("R9", csrRdata, 64'h8000_000A_007E_7FAA);

    // R7 software values stored, R8 summary clear
    swWrite(64'h0000_0000_0000_2400);
    check("R7", csrRdata, 64'h0000_000A_0000_2400);
    check("R8", {63'd0, csrRdata[63]}, 64'd0);
    step(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R7", csrRdata, 64'h8000_000A_0000_6400);
    swWrite(64'd0);
    check("R8", {63'd0, csrRdata[63]}, 64'd0);
    step(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R7", csrRdata, 64'h8000_000A_0000_0600);
    // R11 dirty strobe overrides a written FS value
    step(1'b1, 64'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R11", csrRdata, 64'h8000_000A_0000_6000);

    // R6 MPRV cleared by machine return and by supervisor return
    swWrite(64'h0000_0000_0002_0800);
    check("R6", {63'd0, csrRdata[17]}, 64'd1);
    step(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6", {63'd0, csrRdata[17]}, 64'd0);
    check("R4", {62'd0, curPriv}, 64'd1);
    swWrite(64'h0000_0000_0002_0000);
    step(1'b0, '0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R6", {63'd0, csrRdata[17]}, 64'd0);
    check("R5", {62'd0, curPriv}, 64'd0);

    // R12 side outputs
    swWrite(64'h0000_0000_0000_090A);
    check("R12", {58'd0, mIntEn, sIntEn, mRetPriv, sRetPriv}, {58'd0, 1'b1, 1'b1, 2'd1, 2'd1});
    swWrite(64'h0000_0000_0000_1800);
    check("R12", {58'd0, mIntEn, sIntEn, mRetPriv, sRetPriv}, {58'd0, 1'b0, 1'b0, 2'd3, 2'd0});
    // R10 reserved code keeps M
    swWrite(64'h0000_0000_0000_1000);
    check("R10", {62'd0, mRetPriv}, 64'd3);

    // R1 reset in mid-run
    rstN = 1'b0;
    @(negedge clk);
    check("R1", csrRdata, RESET_VAL);
    check("R1", {62'd0, curPriv}, 64'd3);
    rstN = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule